// File: doc/BRIEF.md
# Address-Dependent Access Cycle Timer

This block keeps the system's master-clock count. Each bus access that the processor makes costs a number of master clocks, and that number depends on the address. Slow memory regions, an extra-slow window for the serial I/O registers and a ROM window whose speed is set by a fast-ROM enable bit each have their own cost. A DMA transfer costs a fixed amount per byte, whatever its address. The block adds the cost of each access to a 64-bit running count and shows that cost on an output until the next access arrives.

A second counter records how many master clocks have already been handed to the video unit. When the master count is at least four clocks ahead of it, the block issues one video step and moves the second counter forward by four. The block issues at most one step per cycle. A long access can therefore leave a backlog, and a busy flag shows it until the video side has caught up. The processor raises `acc_valid` for one cycle with the address, the DMA flag and the fast-ROM setting. The video unit advances one step for each `video_tick` pulse.

Top module: `access_cycle_timer`

## Requirements
- R1: After reset, `acc_cost` is 0, `master_clk` is 0, `video_tick` is 0 and `catchup_busy` is 0.
- R2: A non-DMA access whose bank (`acc_addr[23:16]`) is in 0x40..0x7F costs 8 clocks, whatever the value of `fast_rom_en`.
- R3: A non-DMA access whose bank is 0xCF or higher costs 6 clocks when `fast_rom_en` is 1 and 8 clocks when it is 0.
- R4: For a non-DMA access in any other bank, a page (`acc_addr[15:8]`) of 0x40 or 0x41 costs 12 clocks.
- R5: For a non-DMA access in any other bank, pages 0x60..0x7F cost 8 clocks, and pages 0x00..0x3F and 0x42..0x5F cost 6 clocks.
- R6: For a non-DMA access in any other bank, pages 0x80..0xFF cost 6 clocks when `fast_rom_en` is 1 and 8 clocks when it is 0.
- R7: An access with `acc_dma` set costs 4 clocks for any address and any `fast_rom_en` value.
- R8: In the cycle after an access, `master_clk` equals its earlier value plus the cost of that access. It does not change in a cycle that has no access.
- R9: `acc_cost` shows the cost of the most recent access, one cycle after that access. Cycles without an access leave it unchanged.
- R10: `catchup_busy` is 1 exactly when `master_clk` exceeds the delivered count by 4 or more. In each cycle where it is 1, one `video_tick` pulse follows in the next cycle, and the delivered count grows by 4. No other cycle produces a pulse.
- R11: After enough idle cycles, `catchup_busy` returns to 0. The total number of `video_tick` pulses since reset then equals `master_clk` divided by 4, rounded down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One access in this cycle |
| acc_addr | input | 24 | Bank (23:16) and offset of the access |
| acc_dma | input | 1 | Access is a DMA transfer (fixed cost) |
| fast_rom_en | input | 1 | Selects fast timing for the ROM windows |
| acc_cost | output | 4 | Cost of the most recent access |
| master_clk | output | 64 | Running master-clock total |
| video_tick | output | 1 | One video step in this cycle |
| catchup_busy | output | 1 | Video side is 4 or more clocks behind |

## Verification
On every cycle, the assertions check four things: that idle cycles change neither the count nor the shown cost, that each access moves the count forward by exactly the shown cost, that DMA and slow-bank accesses report their fixed costs, and that a video pulse comes one cycle after each busy cycle and at no other time. The assertions cannot follow the full address decode, the fast-ROM switching or the total number of pulses, because these depend on the whole sequence of accesses. The bench's reference model covers them: it walks every region boundary in both ROM modes, builds a backlog with back-to-back extra-slow accesses, and compares each output on every clock.

// File: rtl/acc_timer_pkg.sv
package acc_timer_pkg;

    typedef enum logic [1:0] {
        RGN_FAST  = 2'd0,
        RGN_SLOW  = 2'd1,
        RGN_XSLOW = 2'd2,
        RGN_ROM   = 2'd3
    } region_e;

    localparam logic [7:0] SLOW_BANK_LO  = 8'h40;
    localparam logic [7:0] SLOW_BANK_HI  = 8'h7F;
    localparam logic [7:0] ROM_BANK_LO   = 8'hCF;
    localparam logic [7:0] XSLOW_PAGE_LO = 8'h40;
    localparam logic [7:0] XSLOW_PAGE_HI = 8'h41;
    localparam logic [7:0] SLOW_PAGE_LO  = 8'h60;
    localparam logic [7:0] SLOW_PAGE_HI  = 8'h7F;
    localparam logic [7:0] ROM_PAGE_LO   = 8'h80;

endpackage

// File: rtl/acc_cost_lookup.sv
module acc_cost_lookup
    import acc_timer_pkg::*;
#(
    parameter int COST_W     = 4,
    parameter int COST_FAST  = 6,
    parameter int COST_SLOW  = 8,
    parameter int COST_XSLOW = 12,
    parameter int COST_DMA   = 4
) (
    input  logic [7:0]        bank_i,
    input  logic [7:0]        page_i,
    input  logic              dma_i,
    input  logic              fast_i,
    output logic [COST_W-1:0] cost_o
);

    region_e region;

    always_comb begin
        if (bank_i >= SLOW_BANK_LO && bank_i <= SLOW_BANK_HI) begin
            region = RGN_SLOW;
        end else if (bank_i >= ROM_BANK_LO) begin
            region = RGN_ROM;
        end else if (page_i >= XSLOW_PAGE_LO && page_i <= XSLOW_PAGE_HI) begin
            region = RGN_XSLOW;
        end else if (page_i >= SLOW_PAGE_LO && page_i <= SLOW_PAGE_HI) begin
            region = RGN_SLOW;
        end else if (page_i >= ROM_PAGE_LO) begin
            region = RGN_ROM;
        end else begin
            region = RGN_FAST;
        end
    end

    always_comb begin
        if (dma_i) begin
            cost_o = COST_W'(COST_DMA);
        end else begin
            unique case (region)
                RGN_FAST:  cost_o = COST_W'(COST_FAST);
                RGN_SLOW:  cost_o = COST_W'(COST_SLOW);
                RGN_XSLOW: cost_o = COST_W'(COST_XSLOW);
                RGN_ROM:   cost_o = fast_i ? COST_W'(COST_FAST) : COST_W'(COST_SLOW);
                default:   cost_o = COST_W'(COST_SLOW);
            endcase
        end
    end

endmodule

// File: rtl/acc_clock_accum.sv
module acc_clock_accum #(
    parameter int COST_W = 4,
    parameter int MCLK_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [COST_W-1:0] cost_i,
    output logic [COST_W-1:0] cost_o,
    output logic [MCLK_W-1:0] mclk_o
);

    localparam int PAD_W = MCLK_W - COST_W;

    typedef struct packed {
        logic [MCLK_W-1:0] mclk;
        logic [COST_W-1:0] cost;
    } accum_t;

    accum_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (valid_i) begin
            st_d.cost = cost_i;
            st_d.mclk = st_q.mclk + {{PAD_W{1'b0}}, cost_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cost_o = st_q.cost;
    assign mclk_o = st_q.mclk;

endmodule

// File: rtl/video_catchup.sv
module video_catchup #(
    parameter int MCLK_W   = 64,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MCLK_W-1:0] mclk_i,
    output logic              tick_o,
    output logic              busy_o
);

    localparam logic [MCLK_W-1:0] LAG  = MCLK_W'(TICK_DIV - 1);
    localparam logic [MCLK_W-1:0] STEP = MCLK_W'(TICK_DIV);

    typedef struct packed {
        logic [MCLK_W-1:0] sent;
        logic              tick;
    } catch_t;

    catch_t st_d, st_q;
    logic   behind;

    always_comb begin
        behind    = (st_q.sent + LAG) < mclk_i;
        st_d      = st_q;
        st_d.tick = behind;
        if (behind) begin
            st_d.sent = st_q.sent + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;
    assign busy_o = behind;

endmodule

// File: rtl/access_cycle_timer.sv
module access_cycle_timer #(
    parameter int COST_W     = 4,
    parameter int MCLK_W     = 64,
    parameter int TICK_DIV   = 4,
    parameter int COST_FAST  = 6,
    parameter int COST_SLOW  = 8,
    parameter int COST_XSLOW = 12,
    parameter int COST_DMA   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [23:0]       acc_addr,
    input  logic              acc_dma,
    input  logic              fast_rom_en,
    output logic [COST_W-1:0] acc_cost,
    output logic [MCLK_W-1:0] master_clk,
    output logic              video_tick,
    output logic              catchup_busy
);

    logic [COST_W-1:0] cost_now;
    logic              unused_offset_low;

    assign unused_offset_low = ^acc_addr[7:0];

    acc_cost_lookup #(
        .COST_W    (COST_W),
        .COST_FAST (COST_FAST),
        .COST_SLOW (COST_SLOW),
        .COST_XSLOW(COST_XSLOW),
        .COST_DMA  (COST_DMA)
    ) lookup_i (
        .bank_i(acc_addr[23:16]),
        .page_i(acc_addr[15:8]),
        .dma_i (acc_dma),
        .fast_i(fast_rom_en),
        .cost_o(cost_now)
    );

    acc_clock_accum #(
        .COST_W(COST_W),
        .MCLK_W(MCLK_W)
    ) accum_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid_i(acc_valid),
        .cost_i (cost_now),
        .cost_o (acc_cost),
        .mclk_o (master_clk)
    );

    video_catchup #(
        .MCLK_W  (MCLK_W),
        .TICK_DIV(TICK_DIV)
    ) catchup_i (
        .clk   (clk),
        .rst_n (rst_n),
        .mclk_i(master_clk),
        .tick_o(video_tick),
        .busy_o(catchup_busy)
    );

endmodule

// File: rtl/access_cycle_timer_chk.sv
module access_cycle_timer_chk #(
    parameter int COST_W    = 4,
    parameter int MCLK_W    = 64,
    parameter int COST_SLOW = 8,
    parameter int COST_DMA  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [7:0]        acc_bank,
    input logic              acc_dma,
    input logic [COST_W-1:0] acc_cost,
    input logic [MCLK_W-1:0] master_clk,
    input logic              video_tick,
    input logic              catchup_busy
);

    localparam int PAD_W = MCLK_W - COST_W;

    p_slow_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_dma && acc_bank >= 8'h40 && acc_bank <= 8'h7F)
            |=> acc_cost == COST_W'(COST_SLOW));

    p_dma_cost_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_dma) |=> acc_cost == COST_W'(COST_DMA));

    p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> master_clk == $past(master_clk) + {{PAD_W{1'b0}}, acc_cost});

    p_idle_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(master_clk));

    p_cost_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(acc_cost));

    p_tick_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        catchup_busy |=> video_tick);

    p_no_stray_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !catchup_busy |=> !video_tick);

endmodule

bind access_cycle_timer access_cycle_timer_chk #(
    .COST_W   (COST_W),
    .MCLK_W   (MCLK_W),
    .COST_SLOW(COST_SLOW),
    .COST_DMA (COST_DMA)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_bank    (acc_addr[23:16]),
    .acc_dma     (acc_dma),
    .acc_cost    (acc_cost),
    .master_clk  (master_clk),
    .video_tick  (video_tick),
    .catchup_busy(catchup_busy)
);

// File: tb/access_cycle_timer_tb_top.sv
module access_cycle_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [23:0] acc_addr = '0;
    logic        acc_dma = 1'b0;
    logic        fast_rom_en = 1'b0;
    logic [3:0]  acc_cost;
    logic [63:0] master_clk;
    logic        video_tick;
    logic        catchup_busy;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    longint m_mclk  = 0;
    longint m_sent  = 0;
    int     m_cost  = 0;
    bit     m_tick  = 0;
    longint m_ticks = 0;
    longint seen_ticks = 0;
    string  tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    access_cycle_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_addr    (acc_addr),
        .acc_dma     (acc_dma),
        .fast_rom_en (fast_rom_en),
        .acc_cost    (acc_cost),
        .master_clk  (master_clk),
        .video_tick  (video_tick),
        .catchup_busy(catchup_busy)
    );

    function automatic int ref_cost(int addr, bit dma, bit fast);
        int bank = (addr >> 16) & 255;
        int page = (addr >> 8) & 255;
        if (dma) return 4;
        if (bank >= 64 && bank < 128) return 8;
        if (bank >= 207) return fast ? 6 : 8;
        if (page == 64 || page == 65) return 12;
        if (page >= 96 && page < 128) return 8;
        if (page >= 128) return fast ? 6 : 8;
        return 6;
    endfunction

    task automatic check(string req, longint act, longint exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit exp_busy = (m_mclk - m_sent) >= 4;
        check(tag,  longint'(acc_cost), longint'(m_cost), "acc_cost");
        check("R8", longint'(master_clk), m_mclk, "master_clk");
        check("R10", longint'(video_tick), longint'(m_tick), "video_tick");
        check("R10", longint'(catchup_busy), longint'(exp_busy), "catchup_busy");
    endtask

    task automatic cycle(bit v, int addr, bit dma, bit fast, string req);
        bit busy_now;
        @(negedge clk);
        compare_all();
        tag         = req;
        acc_valid   = v;
        acc_addr    = addr[23:0];
        acc_dma     = dma;
        fast_rom_en = fast;
        busy_now = (m_mclk - m_sent) >= 4;
        m_tick = busy_now;
        if (busy_now) begin
            m_sent += 4;
            m_ticks++;
        end
        if (v) begin
            m_cost = ref_cost(addr, dma, fast);
            m_mclk += m_cost;
        end
    endtask

    task automatic access(int addr, bit dma, bit fast, string req);
        cycle(1'b1, addr, dma, fast, req);
    endtask

    task automatic idle(int n, string req);
        for (int i = 0; i < n; i++) cycle(1'b0, 0, 1'b0, 1'b0, req);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst_n && video_tick) seen_ticks++;
    end

    initial begin
        wait (cycles >= WATCHDOG);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        compare_all();
        rst_n = 1'b1;

        // R2 slow banks, both modes, boundaries
        access(24'h400000, 0, 0, "R2");
        access(24'h7FFF00, 0, 1, "R2");
        access(24'h408000, 0, 1, "R2");
        // R3 high ROM banks
        access(24'hCF0000, 0, 1, "R3");
        access(24'hCF0000, 0, 0, "R3");
        access(24'hFF4000, 0, 1, "R3");
        access(24'hCE0000, 0, 1, "R3");
        // R4 extra-slow window in other banks
        access(24'h004000, 0, 0, "R4");
        access(24'h8041FF, 0, 1, "R4");
        access(24'h3F4100, 0, 1, "R4");
        // R5 slow and fast pages
        access(24'h006000, 0, 1, "R5");
        access(24'h807FFF, 0, 1, "R5");
        access(24'h003F00, 0, 0, "R5");
        access(24'h004200, 0, 0, "R5");
        access(24'h005F00, 0, 0, "R5");
        access(24'h000000, 0, 0, "R5");
        // R6 ROM pages in other banks
        access(24'h008000, 0, 1, "R6");
        access(24'h008000, 0, 0, "R6");
        access(24'hBFFF00, 0, 0, "R6");
        access(24'hCEFF00, 0, 1, "R6");
        // R7 DMA fixed cost
        access(24'h004000, 1, 0, "R7");
        access(24'h7E0000, 1, 1, "R7");
        access(24'hFF8000, 1, 0, "R7");
        // R9 hold across idle cycles
        access(24'h004100, 0, 0, "R9");
        idle(6, "R9");
        // R10 backlog from back-to-back extra-slow accesses
        for (int i = 0; i < 12; i++) access(24'h804000, 0, 0, "R10");
        idle(3, "R10");
        for (int i = 0; i < 8; i++) access(24'h00_0000 | (i << 13), i[0], i[1], "R8");
        // R11 drain
        idle(60, "R11");
        @(negedge clk);
        compare_all();
        check("R11", longint'(catchup_busy), 0, "busy_after_drain");
        check("R11", seen_ticks, longint'(master_clk) / 4, "tick_total");
        check("R11", m_ticks, m_mclk / 4, "model_tick_total");

        // R1 reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", longint'(acc_cost), 0, "acc_cost_reset");
        check("R1", longint'(master_clk), 0, "master_clk_reset");
        check("R1", longint'(video_tick), 0, "video_tick_reset");
        check("R1", longint'(catchup_busy), 0, "busy_reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule